// File: doc/BRIEF.md
# Circular Return Address Stack

This block predicts where a procedure return will go. Fetch logic that sees a taken call sends the call's return address with a push strobe. The block keeps that address in a small ring of entries. Calls can come from wide or narrow instruction encodings, so the return offset differs, and the caller works out the full address itself. When the fetch logic predicts a return, it reads the current top entry from the prediction outputs and pulses pop in the same cycle to consume it.

The ring never refuses a push. When every entry is live, a new call writes over the oldest one. Popping an empty stack does nothing and the prediction reads as invalid. A flush input empties the stack in one cycle, for use after a pipeline redirect.

Top module: `ret_addr_stack`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pred_valid` is 0.
- R2: A push of address X with no flush makes `pred_valid` 1 and `pred_addr` equal X from the cycle after the push edge.
- R3: Entries come back in last-in, first-out order. After a pop, the outputs show the entry pushed before the popped one, or `pred_valid` 0 if none is left.
- R4: With DEPTH (default 4) entries live, a further push replaces the oldest entry and the live count stays at DEPTH. A later run of pops returns only the newest DEPTH addresses, and then reads as invalid.
- R5: A pop while the stack is empty leaves `pred_valid` 0 and moves no pointer. A following series of pushes and pops behaves as if that pop had never happened.
- R6: Push and pop together on a non-empty stack replace the top entry with the pushed address and leave the live count unchanged. The entries below stay as they were.
- R7: Flush empties the stack at the next edge (`pred_valid` 0). It takes priority over a push or pop in the same cycle.
- R8: Push and pop together on an empty stack act as a plain push, leaving one live entry.
- R9: Every bit of the `AW`-bit address is stored, including bit 0 and halfword-aligned values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empty the stack at the next edge |
| push | input | 1 | A taken call was seen; store `push_addr` |
| push_addr | input | AW | Return address of the call |
| pop | input | 1 | A return is predicted; consume the top entry |
| pred_addr | output | AW | Current top-of-stack address |
| pred_valid | output | 1 | `pred_addr` holds a live entry |

## Verification
The bench goes after wrap-around. If a design saturated instead of overwriting, it would return the stale oldest address on the fourth pop. If it cleared the count on a wrap, it would go invalid too early. Pops on an empty stack are repeated and then followed by pushes: a design that moved its pointer on an empty pop would hand back a wrong entry later. Simultaneous push and pop is tested on both a live and an empty stack, since a wrong design either grows the count or drops the new address. Flush is tested together with a push, which must lose.

// File: rtl/ras_pkg.sv
package ras_pkg;
   // Per-cycle action chosen from the strobes.
   typedef enum logic [2:0] {
      RAS_IDLE  = 3'd0,
      RAS_PUSH  = 3'd1,
      RAS_POP   = 3'd2,
      RAS_SWAP  = 3'd3,
      RAS_CLEAR = 3'd4
   } ras_op_e;
endpackage

// File: rtl/ras_op_dec.sv
module ras_op_dec
   import ras_pkg::*;
(
   input  logic    flush,
   input  logic    push,
   input  logic    pop,
   input  logic    nonempty,
   output ras_op_e op
);
   // Flush wins. A pop on an empty stack is dropped, so push+pop there is a push.
   always_comb begin
      if (flush)                     op = RAS_CLEAR;
      else if (push && pop && nonempty) op = RAS_SWAP;
      else if (push)                 op = RAS_PUSH;
      else if (pop && nonempty)      op = RAS_POP;
      else                           op = RAS_IDLE;
   end
endmodule

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
   import ras_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  ras_op_e       op,
   output logic [PW-1:0] top_idx,
   output logic [PW-1:0] wr_idx,
   output logic          wr_en,
   output logic [CW-1:0] live_cnt
);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   logic [PW-1:0] up_idx, dn_idx;

   // Ring arithmetic that also works when DEPTH is not a power of two.
   assign up_idx = (top_idx == LAST) ? '0 : top_idx + 1'b1;
   assign dn_idx = (top_idx == '0) ? LAST : top_idx - 1'b1;

   assign wr_en  = (op == RAS_PUSH) || (op == RAS_SWAP);
   assign wr_idx = (op == RAS_SWAP) ? top_idx : up_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_idx  <= '0;
         live_cnt <= '0;
      end else begin
         unique case (op)
            RAS_PUSH: begin
               top_idx  <= up_idx;
               live_cnt <= (live_cnt == FULL) ? FULL : live_cnt + 1'b1;
            end
            RAS_POP: begin
               top_idx  <= dn_idx;
               live_cnt <= live_cnt - 1'b1;
            end
            RAS_CLEAR: live_cnt <= '0;
            default: ;
         endcase
      end
   end

   p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      live_cnt <= FULL);

   p_full_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op == RAS_PUSH && live_cnt == FULL) |=> live_cnt == FULL);

   p_empty_pop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op == RAS_IDLE && live_cnt == '0) |=> ($stable(top_idx) && live_cnt == '0));

   p_swap_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op == RAS_SWAP) |=> ($stable(live_cnt) && $stable(top_idx)));

   p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op == RAS_CLEAR) |=> live_cnt == '0);
endmodule

// File: rtl/ras_entry_bank.sv
module ras_entry_bank #(
   parameter int AW    = 32,
   parameter int DEPTH = 4,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [PW-1:0] wr_idx,
   input  logic [AW-1:0] wr_data,
   input  logic [PW-1:0] rd_idx,
   output logic [AW-1:0] rd_data
);
   logic [AW-1:0] slot [DEPTH];

   // One register per entry. Data needs no reset because the live count qualifies it.
   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
      logic [AW-1:0] q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == PW'(gi))) q <= wr_data;
      end
      assign slot[gi] = q;
   end

   assign rd_data = slot[rd_idx];
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
   import ras_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic          pop,
   output logic [AW-1:0] pred_addr,
   output logic          pred_valid
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("ret_addr_stack: DEPTH must be at least 2");
   end
   if (AW < 2) begin : g_bad_aw
      $error("ret_addr_stack: AW must be at least 2");
   end

   ras_op_e       op;
   logic [PW-1:0] top_idx, wr_idx;
   logic          wr_en;
   logic [CW-1:0] live_cnt;

   ras_op_dec u_dec (
      .flush    (flush),
      .push     (push),
      .pop      (pop),
      .nonempty (live_cnt != '0),
      .op       (op)
   );

   ras_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .top_idx  (top_idx),
      .wr_idx   (wr_idx),
      .wr_en    (wr_en),
      .live_cnt (live_cnt)
   );

   ras_entry_bank #(.AW(AW), .DEPTH(DEPTH)) u_bank (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (push_addr),
      .rd_idx  (top_idx),
      .rd_data (pred_addr)
   );

   assign pred_valid = (live_cnt != '0);

   p_push_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !flush) |=> (pred_valid && pred_addr == $past(push_addr)));

   p_flush_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !pred_valid);
endmodule

// File: tb/sim_ret_addr_stack.sv
module sim_ret_addr_stack;
   localparam int AW = 32;

   typedef struct packed {
      logic          fl;
      logic          pu;
      logic          po;
      logic [AW-1:0] a;
      logic          ev;
      logic [AW-1:0] ea;
   } vec_t;

   localparam int NV = 17;
   // Each row: flush, push, pop, push address, expected valid, expected address after the edge.
   localparam vec_t VECS [NV] = '{
      '{1'b0,1'b1,1'b0,32'h0000_1000,1'b1,32'h0000_1000}, // R2 push
      '{1'b0,1'b1,1'b0,32'h0000_2002,1'b1,32'h0000_2002}, // R2 R9 halfword address
      '{1'b0,1'b0,1'b1,32'h0,        1'b1,32'h0000_1000}, // R3 LIFO pop
      '{1'b0,1'b1,1'b1,32'h0000_3004,1'b1,32'h0000_3004}, // R6 swap on top
      '{1'b0,1'b0,1'b1,32'h0,        1'b0,32'h0},         // R6 count unchanged, now empty
      '{1'b0,1'b0,1'b1,32'h0,        1'b0,32'h0},         // R5 pop on empty
      '{1'b0,1'b1,1'b1,32'h0000_4006,1'b1,32'h0000_4006}, // R8 swap on empty acts as push
      '{1'b0,1'b0,1'b1,32'h0,        1'b0,32'h0},         // R8 one entry only
      '{1'b0,1'b1,1'b0,32'hA000_0001,1'b1,32'hA000_0001}, // R4 R9 fill
      '{1'b0,1'b1,1'b0,32'hB000_0002,1'b1,32'hB000_0002}, // R4
      '{1'b0,1'b1,1'b0,32'hC000_0003,1'b1,32'hC000_0003}, // R4
      '{1'b0,1'b1,1'b0,32'hD000_0004,1'b1,32'hD000_0004}, // R4 full
      '{1'b0,1'b1,1'b0,32'hFFFF_FFFF,1'b1,32'hFFFF_FFFF}, // R4 R9 overwrite oldest
      '{1'b0,1'b0,1'b1,32'h0,        1'b1,32'hD000_0004}, // R4 R3
      '{1'b0,1'b0,1'b1,32'h0,        1'b1,32'hC000_0003}, // R4 R3
      '{1'b0,1'b0,1'b1,32'h0,        1'b1,32'hB000_0002}, // R4 R3
      '{1'b0,1'b0,1'b1,32'h0,        1'b0,32'h0}          // R4 oldest is gone
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush = 1'b0;
   logic          push = 1'b0;
   logic          pop = 1'b0;
   logic [AW-1:0] push_addr = '0;
   logic [AW-1:0] pred_addr;
   logic          pred_valid;
   int            n_chk = 0;
   int            n_bad = 0;
   bit            done = 1'b0;

   always #5 clk = ~clk;

   ret_addr_stack #(.AW(AW), .DEPTH(4)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .push       (push),
      .push_addr  (push_addr),
      .pop        (pop),
      .pred_addr  (pred_addr),
      .pred_valid (pred_valid)
   );

   task automatic chk(input string tag, input logic ev, input logic [AW-1:0] ea);
      n_chk++;
      if (pred_valid !== ev || (ev && pred_addr !== ea)) begin
         n_bad++;
         $display("FAIL %s: valid=%0b addr=%h expected valid=%0b addr=%h",
                  tag, pred_valid, pred_addr, ev, ea);
      end
   endtask

   task automatic step(input logic f, input logic pu, input logic po, input logic [AW-1:0] a);
      @(negedge clk);
      flush = f; push = pu; pop = po; push_addr = a;
      @(posedge clk);
      #1;
      flush = 1'b0; push = 1'b0; pop = 1'b0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 chk("R1 in reset", 1'b0, '0);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1 chk("R1 after reset", 1'b0, '0);

      for (int i = 0; i < NV; i++) begin
         step(VECS[i].fl, VECS[i].pu, VECS[i].po, VECS[i].a);
         chk($sformatf("table row %0d", i), VECS[i].ev, VECS[i].ea);
      end

      // R5: several empty pops, then the ring must still order correctly
      step(0, 0, 1, '0); chk("R5 extra empty pop", 1'b0, '0);
      step(0, 1, 0, 32'h0000_7770); chk("R5 push P", 1'b1, 32'h0000_7770);
      step(0, 1, 0, 32'h0000_8882); chk("R5 push Q", 1'b1, 32'h0000_8882);
      step(0, 0, 1, '0); chk("R5 pop back to P", 1'b1, 32'h0000_7770);

      // R6: swap keeps the entry beneath
      step(0, 1, 1, 32'h0000_9994); chk("R6 swap top", 1'b1, 32'h0000_9994);
      step(0, 1, 0, 32'h0000_AAA6); chk("R6 push above", 1'b1, 32'h0000_AAA6);
      step(0, 0, 1, '0); chk("R6 swapped entry remains", 1'b1, 32'h0000_9994);

      // R7: flush empties, and wins over a push in the same cycle
      step(1, 0, 0, '0); chk("R7 flush", 1'b0, '0);
      step(0, 1, 0, 32'h0000_1230); chk("R7 push after flush", 1'b1, 32'h0000_1230);
      step(1, 1, 0, 32'h0000_4560); chk("R7 flush beats push", 1'b0, '0);
      step(0, 0, 1, '0); chk("R7 still empty", 1'b0, '0);

      done = 1'b1;
      finish_run();
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: valid=%0b addr=%h expected valid=x addr=x", pred_valid, pred_addr);
         finish_run();
      end
   end
endmodule